// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a small 8-bit accumulator processor that keeps program and data in one 16-byte memory. Every instruction is a single byte. The high nibble selects the operation and the low nibble holds a memory address or a 4-bit immediate. The datapath has these registers:

- a program counter
- an address latch for the memory
- an instruction latch
- the accumulator A and an operand register B
- a carry flag and a zero flag
- an output latch

A finite-state sequencer drives the datapath.

The sequencer passes through named states:

- `ST_FETCH` copies the program counter into the address latch.
- `ST_LATCH` loads the addressed byte into the instruction latch and steps the program counter.
- `ST_EXEC` decodes the opcode. Immediate loads, jumps, output and no-ops finish here and return to `ST_FETCH`. Memory operations point the address latch at the operand and move to `ST_MEMOP`. A halt moves to `ST_HALT`.
- `ST_MEMOP` loads A, stores A, or captures the operand into B. Addition and subtraction continue to `ST_ALU`; the other memory operations return to `ST_FETCH`.
- `ST_ALU` writes the adder result and both flags, then returns to `ST_FETCH`.
- `ST_HALT` is left only by reset.

The program image is written through a preload port while reset is held. Results appear on an 8-bit output port together with a one-cycle valid strobe.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, the program counter, A, B, both flags and the output latch are cleared, `out_valid` is low, `out_data` is 0 and `halted` is low; reset also leaves the halt state.
- R2: Instructions are fetched at the program counter, which advances by one per fetched byte and wraps from 15 to 0. Bits 7:4 of each byte are the opcode and bits 3:0 are the operand.
- R3: Opcode 5 (load immediate) sets A to the operand nibble zero-extended. Opcode 1 (load) sets A to the memory byte at the operand address.
- R4: Opcode 4 (store) writes A into memory at the operand address.
- R5: Opcode 2 (add) sets A to A plus the addressed byte, modulo 256. Carry becomes bit 8 of the sum, and zero is set when the 8-bit result is 0.
- R6: Opcode 3 (subtract) sets A to A plus the two's complement of the addressed byte. Carry is set when no borrow occurs (A ≥ operand), and zero is set on a 0 result.
- R7: The carry and zero flags change only on add and subtract; every other opcode leaves them unchanged.
- R8: Opcode 6 always loads the program counter with the operand. Opcode 7 does so only when carry is set, and opcode 8 only when zero is set.
- R9: Opcode E copies A into `out_data` and raises `out_valid` for exactly one cycle. `out_data` changes only together with such a pulse.
- R10: Opcode F stops execution: `halted` rises and stays high, and no output, program counter or flag change happens until reset.
- R11: Opcodes 0 and 9 through D do nothing but advance to the next instruction.
- R12: While `rst_n` is low, a cycle with `ld_en` high writes `ld_data` into memory at `ld_addr`. `ld_en` is ignored while running.
- R13: The image 51 4E 50 4F E0 1E 2F 4E E0 1F 2E 7D 63 60 00 01 outputs 0, 1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233. It then restarts and repeats this series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write enable, honoured during reset |
| ld_addr | input | 4 | Preload address |
| ld_data | input | 8 | Preload byte |
| out_data | output | 8 | Output latch |
| out_valid | output | 1 | One-cycle strobe per output instruction |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Some properties are checked on every cycle:

- the output strobe never lasts longer than one cycle
- the output value never changes without a strobe
- the halt state is sticky and freezes the program counter and the output
- the flags move only in the cycle after the sequencer's ALU step

The arithmetic values, the carry and zero meaning of subtraction, branch decisions, the treatment of unused opcodes and the preload path are shown only by the bench's programs. In those programs, a wrong flag or a wrongly taken branch produces a different output series.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'h0,
        OP_LOAD = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_STOR = 4'h4,
        OP_IMM  = 4'h5,
        OP_JUMP = 4'h6,
        OP_JCRY = 4'h7,
        OP_JZER = 4'h8,
        OP_EMIT = 4'hE,
        OP_STOP = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_MEMOP,
        ST_ALU,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic mar_pc;
        logic mar_opnd;
        logic ir_ld;
        logic pc_inc;
        logic pc_ld;
        logic a_imm;
        logic a_mem;
        logic a_alu;
        logic b_ld;
        logic mem_we;
        logic alu_sub;
        logic flags_ld;
        logic out_ld;
    } ctrl_t;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          zero
);
    logic [DW:0]   sum;
    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
        res   = sum[DW-1:0];
        cout  = sum[DW];
        zero  = (sum[DW-1:0] == '0);
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPW-1:0]     opcode,
    input  logic               carry,
    input  logic               zero,
    output acc_cpu_pkg::ctrl_t ctl,
    output logic               halted
);
    state_e state_q, state_d;
    logic   is_mem_op, is_alu_op, take_jump;

    always_comb begin
        is_mem_op = (opcode == OP_LOAD) || (opcode == OP_STOR) ||
                    (opcode == OP_ADD)  || (opcode == OP_SUB);
        is_alu_op = (opcode == OP_ADD) || (opcode == OP_SUB);
        take_jump = (opcode == OP_JUMP) ||
                    ((opcode == OP_JCRY) && carry) ||
                    ((opcode == OP_JZER) && zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_LATCH;
            ST_LATCH: state_d = ST_EXEC;
            ST_EXEC: begin
                if (opcode == OP_STOP) state_d = ST_HALT;
                else if (is_mem_op)    state_d = ST_MEMOP;
                else                   state_d = ST_FETCH;
            end
            ST_MEMOP: state_d = is_alu_op ? ST_ALU : ST_FETCH;
            ST_ALU:   state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state_q)
            ST_FETCH: ctl.mar_pc = 1'b1;
            ST_LATCH: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_EXEC: begin
                ctl.mar_opnd = is_mem_op;
                ctl.a_imm    = (opcode == OP_IMM);
                ctl.pc_ld    = take_jump;
                ctl.out_ld   = (opcode == OP_EMIT);
            end
            ST_MEMOP: begin
                ctl.a_mem  = (opcode == OP_LOAD);
                ctl.mem_we = (opcode == OP_STOR);
                ctl.b_ld   = is_alu_op;
            end
            ST_ALU: begin
                ctl.a_alu    = 1'b1;
                ctl.flags_ld = 1'b1;
                ctl.alu_sub  = (opcode == OP_SUB);
            end
            ST_HALT: halted = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [AW-1:0]       ld_addr,
    input  logic [OPW+AW-1:0]   ld_data,
    output logic [OPW+AW-1:0]   out_data,
    output logic                out_valid,
    output logic                halted
);
    localparam int DW = OPW + AW;

    ctrl_t         ctl;
    logic [AW-1:0] pc_q, mar_q;
    logic [DW-1:0] ir_q, a_q, b_q, out_q;
    logic          cf_q, zf_q, valid_q;
    logic [DW-1:0] mem_rd, alu_res, wr_data;
    logic [AW-1:0] wr_addr;
    logic          wr_en, alu_c, alu_z;

    always_comb begin
        wr_en   = (!rst_n && ld_en) || ctl.mem_we;
        wr_addr = !rst_n ? ld_addr : mar_q;
        wr_data = !rst_n ? ld_data : a_q;
    end

    acc_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (mar_q),
        .rdata (mem_rd)
    );

    acc_alu #(.DW(DW)) u_alu (
        .a    (a_q),
        .b    (b_q),
        .sub  (ctl.alu_sub),
        .res  (alu_res),
        .cout (alu_c),
        .zero (alu_z)
    );

    acc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_q[DW-1:AW]),
        .carry  (cf_q),
        .zero   (zf_q),
        .ctl    (ctl),
        .halted (halted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            mar_q   <= '0;
            ir_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            cf_q    <= 1'b0;
            zf_q    <= 1'b0;
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= ctl.out_ld;
            if (ctl.mar_pc)   mar_q <= pc_q;
            if (ctl.mar_opnd) mar_q <= ir_q[AW-1:0];
            if (ctl.ir_ld)    ir_q  <= mem_rd;
            if (ctl.pc_inc)   pc_q  <= pc_q + 1'b1;
            if (ctl.pc_ld)    pc_q  <= ir_q[AW-1:0];
            if (ctl.a_imm)    a_q   <= {{OPW{1'b0}}, ir_q[AW-1:0]};
            if (ctl.a_mem)    a_q   <= mem_rd;
            if (ctl.a_alu)    a_q   <= alu_res;
            if (ctl.b_ld)     b_q   <= mem_rd;
            if (ctl.flags_ld) begin
                cf_q <= alu_c;
                zf_q <= alu_z;
            end
            if (ctl.out_ld)   out_q <= a_q;
        end
    end

    assign out_data  = out_q;
    assign out_valid = valid_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          halted,
    input logic [AW-1:0] pc,
    input logic [1:0]    flags,
    input logic          flags_ld
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9

    AST_OUT_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10

    AST_HALT_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !out_valid); // R10

    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R10

    AST_FLAGS_ONLY_ON_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_ld |=> $stable(flags)); // R7
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(OPW + AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_data  (out_data),
    .halted    (halted),
    .pc        (pc_q),
    .flags     ({cf_q, zf_q}),
    .flags_ld  (ctl.flags_ld)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       halted;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    acc_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every strobed output against the scoreboard.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected output", out_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.val, e.req, out_data, e.val);
            end
        end
    end

    task automatic load_image(input logic [7:0] img [16]);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 4'(i);
            ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_until_drained(input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        logic [7:0] p_sub [16];
        logic [7:0] p_flag [16];
        logic [7:0] p_fib [16];
        logic [7:0] fib [14];

        p_sub  = '{8'h55, 8'h4F, 8'h3F, 8'h85, 8'h5A, 8'hE0, 8'h9C, 8'h3F,
                   8'h7A, 8'hE0, 8'h2F, 8'h7D, 8'h5A, 8'hE0, 8'hF0, 8'h00};
        p_flag = '{8'h3F, 8'h57, 8'h84, 8'h50, 8'hE0, 8'h78, 8'h50, 8'hE0,
                   8'h1F, 8'h8B, 8'h5A, 8'hE0, 8'h9D, 8'hD0, 8'hF0, 8'h00};
        p_fib  = '{8'h51, 8'h4E, 8'h50, 8'h4F, 8'hE0, 8'h1E, 8'h2F, 8'h4E,
                   8'hE0, 8'h1F, 8'h2E, 8'h7D, 8'h63, 8'h60, 8'h00, 8'h01};
        fib    = '{8'd0, 8'd1, 8'd1, 8'd2, 8'd3, 8'd5, 8'd8, 8'd13,
                   8'd21, 8'd34, 8'd55, 8'd89, 8'd144, 8'd233};

        // R1 / R12: reset state while the first image is preloaded.
        load_image(p_sub);
        check(out_data == 8'h00, "R1 out_data in reset", out_data, 0);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(halted == 1'b0, "R1 halted in reset", halted, 0);

        // Subtract, branches and the unused opcode.
        push_exp(8'h00, "R6 R8 SUB to zero then JZ taken");
        push_exp(8'hFB, "R6 R11 borrow clears carry, JC not taken");
        push_exp(8'h00, "R5 R8 ADD wraps and sets carry, JC taken");
        @(negedge clk);
        rst_n = 1'b1;
        run_until_drained(2000);
        check(exp_q.size() == 0, "R9 missing outputs program 1", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        check(halted == 1'b1, "R10 halted after HLT", halted, 1);
        // Driving the preload port while running must not alter the run.
        ld_en   = 1'b1;
        ld_addr = 4'hE;
        ld_data = 8'hE0;
        repeat (50) @(negedge clk);
        ld_en = 1'b0;
        check(halted == 1'b1, "R10 R12 still halted", halted, 1);
        check(out_data == 8'h00, "R10 output frozen", out_data, 0);

        // Flags survive non-arithmetic instructions. Reset releases the halt.
        load_image(p_flag);
        check(halted == 1'b0, "R1 reset releases halt", halted, 0);
        check(out_data == 8'h00, "R1 output cleared", out_data, 0);
        push_exp(8'h07, "R3 R7 JZ uses zero from SUB across LDI");
        push_exp(8'h00, "R3 R7 R11 JC and JZ use old flags across LDA");
        @(negedge clk);
        rst_n = 1'b1;
        run_until_drained(2000);
        check(exp_q.size() == 0, "R9 missing outputs program 2", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        check(halted == 1'b1, "R10 halted after program 2", halted, 1);

        // R13: Fibonacci image, two full periods.
        load_image(p_fib);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 14; i++) push_exp(fib[i], "R13 R2 R4 series value");
        end
        @(negedge clk);
        rst_n = 1'b1;
        run_until_drained(20000);
        check(exp_q.size() == 0, "R13 missing series outputs", exp_q.size(), 0);
        check(halted == 1'b0, "R13 series never halts", halted, 0);

        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        check(1'b0, "watchdog expired", cycles, 0);
        finish_run();
    end
endmodule